// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Reload

This peripheral keeps a 64-bit up-counter that advances once per clock while it is running. A 64-bit compare value sits next to it. When the count reaches or passes the compare value, an event flag is latched and, if interrupts are enabled, a level interrupt is raised. The counter does not stop or wrap back at the event. Software reaches everything through a plain 32-bit register bus: each 64-bit quantity is split into a low and a high word, and reads return data combinationally in the same cycle.

Two timing styles are supported. In one-shot use, a compare value raises one event and then stays quiet until software writes a new compare value. In periodic use, every event adds a programmed 32-bit step to the 64-bit compare value inside the block. The next event then arrives that many cycles later with no software reload. Because the counter words are not latched, a carry from the low word must show in the high word in the same cycle. Software can then get a consistent value by reading high, low and high again.

Top module: `cmp_timer64`

## Requirements
- R1: After reset the counter, compare value, step, control and status all read 0 and `irq` is low.
- R2: Word offsets on `bus_addr`: 0x00 counter low, 0x04 counter high, 0x08 control, 0x0C status, 0x10 compare low, 0x14 compare high, 0x18 step. Control keeps bits 3:0 (bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-reload), its upper bits read 0, and any other offset reads 0.
- R3: While control bit 0 is set the counter grows by exactly 1 per clock. While it is clear the counter holds.
- R4: The full 64-bit value is one register, so a carry out of the low word shows in the high word in the same cycle.
- R5: With compare enabled and an armed compare value, a count at or above it sets status bit 0 on the next edge. The counter keeps running, and `irq` equals status bit 0 AND control bit 2.
- R6: Without auto-reload, a compare value raises at most one event. A new event needs a write to either compare word, which re-arms it.
- R7: With auto-reload, each event adds the 32-bit step to the full 64-bit compare value, carrying into the high word.
- R8: Writing 1 to status bit 0 clears the flag, writing 0 there does nothing, and a new event in the same cycle wins over the clear.
- R9: A compare value written below the current count fires on the next cycle in which compare is enabled.
- R10: Both counter words can be written by software, and the written value reads back while the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs the counter across a low-word wrap. It reads both halves between two edges and requires every sample pair to be exactly one above the last; a design that registers the carry a cycle late would show the high word one step behind at the wrap. A one-shot event is timed against the counter and then watched for a repeat, which catches a design that keeps firing while the count stays above the compare value. Periodic events are checked for the exact step spacing and for the comparator carrying into its high word. Flag clearing, ignored zero writes, interrupt masking and a compare value already in the past each get a directed case, since a wrong design would either drop the event or keep the interrupt stuck.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 2;

  localparam logic [7:0] OFF_CNT_LO  = 8'h00;
  localparam logic [7:0] OFF_CTRL    = 8'h08;
  localparam logic [7:0] OFF_STAT    = 8'h0C;
  localparam logic [7:0] OFF_CMP_LO  = 8'h10;
  localparam logic [7:0] OFF_STEP    = 8'h18;
  localparam int         WORD_BYTES  = 4;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic auto_rld;
    logic irq_en;
    logic cmp_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif #(
  parameter int WORD_W = tmr_pkg::WORD_W,
  parameter int NWORDS = tmr_pkg::NWORDS,
  parameter int ADDR_W = 5,
  localparam int CW    = WORD_W * NWORDS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [CW-1:0]       cnt,
  input  logic [CW-1:0]       cmp,
  input  logic [WORD_W-1:0]   step,
  input  logic                flag,
  output tmr_pkg::ctrl_t      ctrl,
  output logic [NWORDS-1:0]   wr_cnt,
  output logic [NWORDS-1:0]   wr_cmp,
  output logic                wr_step,
  output logic                clr_flag
);
  import tmr_pkg::*;

  logic wr_any;
  assign wr_any = bus_sel & bus_wr;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  genvar w;
  generate
    for (w = 0; w < NWORDS; w++) begin : g_strobe
      assign wr_cnt[w] = wr_any & at(bus_addr, OFF_CNT_LO + 8'(w * WORD_BYTES));
      assign wr_cmp[w] = wr_any & at(bus_addr, OFF_CMP_LO + 8'(w * WORD_BYTES));
    end
  endgenerate

  assign wr_step  = wr_any & at(bus_addr, OFF_STEP);
  assign clr_flag = wr_any & at(bus_addr, OFF_STAT) & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_any && at(bus_addr, OFF_CTRL)) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (at(bus_addr, OFF_CNT_LO + 8'(i * WORD_BYTES))) bus_rdata = cnt[i*WORD_W +: WORD_W];
      if (at(bus_addr, OFF_CMP_LO + 8'(i * WORD_BYTES))) bus_rdata = cmp[i*WORD_W +: WORD_W];
    end
    if (at(bus_addr, OFF_CTRL)) bus_rdata = WORD_W'(ctrl);
    if (at(bus_addr, OFF_STAT)) bus_rdata = WORD_W'(flag);
    if (at(bus_addr, OFF_STEP)) bus_rdata = step;
  end

  // R2: control keeps only its defined bits
  assert_ctrl_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && at(bus_addr, OFF_CTRL)) |=> (WORD_W'(ctrl) == ($past(bus_wdata) & WORD_W'((1 << CTRL_W) - 1))));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int WORD_W = tmr_pkg::WORD_W,
  parameter int NWORDS = tmr_pkg::NWORDS,
  localparam int CW    = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NWORDS-1:0] wr_word,
  input  logic [WORD_W-1:0] wdata,
  output logic [CW-1:0]     cnt
);
  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return v + CW'(1);
  endfunction

  logic [CW-1:0] cnt_nxt;
  logic          sw_load;

  assign sw_load = |wr_word;

  always_comb begin
    cnt_nxt = run ? bump(cnt) : cnt;
    for (int i = 0; i < NWORDS; i++)
      if (wr_word[i]) cnt_nxt[i*WORD_W +: WORD_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R3 and R4: one step per running cycle across the whole width
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sw_load) |=> (cnt == $past(cnt) + CW'(1)));
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_load) |=> $stable(cnt));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int WORD_W = tmr_pkg::WORD_W,
  parameter int NWORDS = tmr_pkg::NWORDS,
  localparam int CW    = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cnt,
  input  logic              cmp_en,
  input  logic              auto_rld,
  input  logic [NWORDS-1:0] wr_cmp,
  input  logic              wr_step,
  input  logic              clr_flag,
  input  logic [WORD_W-1:0] wdata,
  output logic [CW-1:0]     cmp,
  output logic [WORD_W-1:0] step,
  output logic              flag,
  output logic              hit
);
  function automatic logic reached(input logic [CW-1:0] c, input logic [CW-1:0] k);
    return c >= k;
  endfunction

  function automatic logic [CW-1:0] advance(input logic [CW-1:0] k, input logic [WORD_W-1:0] s);
    return k + CW'(s);
  endfunction

  logic armed;
  logic cmp_load;

  assign cmp_load = |wr_cmp;
  assign hit      = cmp_en & armed & reached(cnt, cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp   <= '0;
      armed <= 1'b1;
    end else if (cmp_load) begin
      for (int i = 0; i < NWORDS; i++)
        if (wr_cmp[i]) cmp[i*WORD_W +: WORD_W] <= wdata;
      armed <= 1'b1;
    end else if (hit) begin
      if (auto_rld) cmp   <= advance(cmp, step);
      else          armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= '0;
    else if (wr_step) step <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end

  // R5: the flag only rises after an event
  assert_flag_from_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
  // R6: one-shot does not repeat without a rewrite
  assert_oneshot_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !auto_rld && !cmp_load) |=> !hit);
  // R7: auto-reload adds the step
  assert_reload_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_rld && !cmp_load) |=> (cmp == $past(cmp) + CW'($past(step))));
  // R8: a clear with no event empties the flag; an event wins
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !hit) |=> !flag);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64 #(
  parameter int ADDR_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  import tmr_pkg::*;
  localparam int CW = WORD_W * NWORDS;

  ctrl_t              ctrl;
  logic [NWORDS-1:0]  wr_cnt;
  logic [NWORDS-1:0]  wr_cmp;
  logic               wr_step;
  logic               clr_flag;
  logic [CW-1:0]      cnt;
  logic [CW-1:0]      cmp;
  logic [WORD_W-1:0]  step;
  logic               flag;
  logic               hit;

  tmr_regif #(.WORD_W(WORD_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(ADDR_W'(bus_addr)), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .cmp(cmp), .step(step), .flag(flag), .ctrl(ctrl),
    .wr_cnt(wr_cnt), .wr_cmp(wr_cmp), .wr_step(wr_step), .clr_flag(clr_flag)
  );

  tmr_counter #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .wr_word(wr_cnt),
    .wdata(bus_wdata), .cnt(cnt)
  );

  tmr_match #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_match (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_en(ctrl.cmp_en),
    .auto_rld(ctrl.auto_rld), .wr_cmp(wr_cmp), .wr_step(wr_step),
    .clr_flag(clr_flag), .wdata(bus_wdata), .cmp(cmp), .step(step),
    .flag(flag), .hit(hit)
  );

  assign irq = flag & ctrl.irq_en;

  // R5: the interrupt only rises once the flag is held or an event arrives
  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (flag && ($past(hit) || $past(flag))));
endmodule

// File: tb/test_cmp_timer64.sv
`timescale 1ns/1ps
module test_cmp_timer64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer64 i_cmp_timer64 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_STA = 5'h0C,
                         A_KLO = 5'h10, A_KHI = 5'h14, A_STP = 5'h18;

  // address, write data, expected read-back
  localparam int NV = 8;
  localparam logic [68:0] VEC [NV] = '{
    {5'h10, 32'h1234_5678, 32'h1234_5678},
    {5'h14, 32'h9ABC_DEF0, 32'h9ABC_DEF0},
    {5'h18, 32'h0000_0100, 32'h0000_0100},
    {5'h08, 32'hFFFF_FFF0, 32'h0000_0000},
    {5'h08, 32'h0000_000C, 32'h0000_000C},
    {5'h08, 32'h0000_0000, 32'h0000_0000},
    {5'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'h04, 32'h0000_0001, 32'h0000_0001}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic rd64(input logic [4:0] a_lo, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 5'd4, hi);
    v = {hi, lo};
  endtask

  task automatic wait_flag(output logic [63:0] c, output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    c = '0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rd(A_STA, s);
      if (s[0]) begin
        rd64(A_CLO, c);
        ok = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v, p, c;
    bit ok, carry_seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    begin
      logic [4:0] regs [7] = '{A_CLO, A_CHI, A_CTL, A_STA, A_KLO, A_KHI, A_STP};
      for (int i = 0; i < 7; i++) begin
        rd(regs[i], d);
        chk("R1 reset value", d, 0);
      end
    end
    chk("R1 irq low", irq, 0);

    // R2, R10: register map walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], d);
      chk("R2 R10 read-back", d, VEC[i][31:0]);
    end
    rd(5'h1C, d);
    chk("R2 unmapped offset", d, 0);

    // R3: counter holds while stopped
    rd64(A_CLO, p);
    repeat (4) @(negedge clk);
    rd64(A_CLO, v);
    chk("R3 hold while stopped", v, p);
    chk("R10 loaded counter", v, 64'h0000_0001_DEAD_BEEF);

    // R3, R4: carry from low to high word
    wr(A_CLO, 32'hFFFF_FFFD);
    wr(A_CHI, 32'h0000_0005);
    wr(A_CTL, 32'h1);
    rd64(A_CLO, p);
    carry_seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rd64(A_CLO, v);
      chk("R3 R4 one step per cycle", v, p + 64'd1);
      if (v == 64'h0000_0006_0000_0000) carry_seen = 1'b1;
      p = v;
    end
    chk("R4 carry seen in high word", carry_seen, 1);

    // R5, R6: one-shot event
    wr(A_CTL, 32'h0);
    wr(A_CLO, 32'h0);
    wr(A_CHI, 32'h0);
    wr(A_STA, 32'h1);
    wr(A_KLO, 32'd20);
    wr(A_KHI, 32'h0);
    wr(A_STP, 32'h0);
    wr(A_CTL, 32'h7);
    wait_flag(c, ok);
    chk("R5 event raised", ok, 1);
    chk("R5 counter at flag", c, 64'd21);
    chk("R5 irq with enable", irq, 1);
    @(negedge clk);
    rd64(A_CLO, v);
    chk("R5 counter keeps running", v, c + 64'd1);

    // R8: zero writes ignored, one clears
    wr(A_STA, 32'hFFFF_FFFE);
    rd(A_STA, d);
    chk("R8 write-0 ignored", d, 1);
    wr(A_STA, 32'h1);
    rd(A_STA, d);
    chk("R8 write-1 clears", d, 0);
    chk("R8 irq drops", irq, 0);

    // R6: no repeat in one-shot
    repeat (30) @(negedge clk);
    rd(A_STA, d);
    chk("R6 one-shot stays quiet", d, 0);

    // R9 and R5 masking: compare value already passed
    wr(A_CTL, 32'h3);
    wr(A_KLO, 32'd5);
    wait_flag(c, ok);
    chk("R9 past value fires", ok, 1);
    chk("R5 irq masked", irq, 0);
    wr(A_CTL, 32'h7);
    chk("R5 irq unmasked", irq, 1);
    wr(A_STA, 32'h1);

    // R7: periodic events at the step
    wr(A_CTL, 32'h0);
    wr(A_CLO, 32'h0);
    wr(A_CHI, 32'h0);
    wr(A_STA, 32'h1);
    wr(A_KLO, 32'd10);
    wr(A_KHI, 32'h0);
    wr(A_STP, 32'd7);
    wr(A_CTL, 32'hF);
    for (int k = 0; k < 4; k++) begin
      wait_flag(c, ok);
      chk("R7 periodic event timing", c, 64'(11 + 7 * k));
      if (k == 3) begin
        rd64(A_KLO, v);
        chk("R7 compare advanced", v, 64'd38);
      end
      wr(A_STA, 32'h1);
    end

    // R7: reload carries into compare high word
    wr(A_CTL, 32'h0);
    wr(A_CLO, 32'hFFFF_FFF0);
    wr(A_CHI, 32'h0);
    wr(A_KHI, 32'h0);
    wr(A_KLO, 32'hFFFF_FFF8);
    wr(A_STP, 32'h10);
    wr(A_STA, 32'h1);
    wr(A_CTL, 32'hB);
    wait_flag(c, ok);
    chk("R7 reload event", ok, 1);
    rd64(A_KLO, v);
    chk("R7 compare carry", v, 64'h0000_0001_0000_0008);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule